// File: doc/BRIEF.md
# Long-Period Sampling Event Counter

This block counts occurrences of a one-bit event and raises a sampling interrupt once a programmed number of events has been seen. The programmed period may be almost twice as wide as the hardware count register. The count register's top bit is its only overflow flag, so one pass of the register covers at most half its range. The block splits a long period into passes of that size. At the end of each pass it reloads the register without telling anyone, and it raises the external interrupt only when the whole period has run out.

Software programs the period in two halves through a small write port. It starts counting by setting an enable bit and acknowledges the interrupt through a write-one clear bit. After the final pass of a period the block starts the next period at once, so a steady event stream produces a steady series of samples.

Top module: `lpc_sampler`

## Requirements
- R1: While reset is asserted and after its release, `irq_o` is low and counting is disabled.
- R2: The write port decodes `wr_sel_i`. Value 0 writes the low `CNT_W` bits of the period. Value 1 writes the upper `CNT_W-1` bits, taken from the low bits of `wr_data_i`. Value 2 writes control: bit 0 is enable and bit 1 is a write-one interrupt clear.
- R3: A control write that takes enable from 0 to 1 arms the counter with the full programmed period. An event sampled in that same cycle is not counted. While enable is 0, events are ignored.
- R4: When the remaining period is at least 2^(CNT_W-1), a pass loads the count register with zero and spans 2^(CNT_W-1) events. Otherwise it loads 2^(CNT_W-1) minus the remaining value, so the top bit sets on exactly the last event.
- R5: A top-bit set that does not finish the period never raises `irq_o`. The block clears it by reloading on the next clock.
- R6: With period P, `irq_o` goes high at the clock edge that follows the edge sampling the P-th counted event.
- R7: After the final pass, the next period begins immediately. An event in the reload cycle counts toward the new period.
- R8: A programmed period of zero behaves as a period of one.
- R9: `irq_o` stays high until a control write with bit 1 set. If a period completes in the same cycle as the clear, the interrupt stays set.
- R10: Rewriting the period while counting leaves the period in progress unchanged. The new value applies from the next period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select |
| wr_data_i | input | CNT_W | Write data |
| event_i | input | 1 | Event input, one count per cycle when high |
| irq_o | output | 1 | Sticky sample interrupt |

## Verification
The assertions assume that software does not disable counting, rearm it or rewrite the period in the two cycles after a period's last event. In those cycles the pending final pass is still being reloaded. They also assume that the event input is idle during the cycle of an enabling write. The stimulus keeps events quiet around every write except interrupt clears, which it deliberately overlaps with a continuous event stream so that a clear can coincide with a completion. The reference model only counts events and compares the count with the period. It never models passes, so the pass splitting in R4 and R5 is checked through interrupt timing alone.

// File: rtl/lpc_pkg.sv
package lpc_pkg;
  typedef enum logic [1:0] {
    SEL_PER_LO = 2'd0,
    SEL_PER_HI = 2'd1,
    SEL_CTRL   = 2'd2,
    SEL_RSVD   = 2'd3
  } sel_e;

  localparam int CTRL_EN  = 0;
  localparam int CTRL_CLR = 1;
endpackage

// File: rtl/lpc_regs.sv
module lpc_regs
  import lpc_pkg::*;
#(
  parameter  int CNT_W = 32,
  localparam int PER_W = 2 * CNT_W - 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_sel_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic [PER_W-1:0] period_o,
  output logic             en_o,
  output logic             arm_o,
  output logic             clr_o
);
  logic [PER_W-1:0] period_q;
  logic             en_q;
  logic             ctrl_wr;

  assign ctrl_wr = wr_en_i && (wr_sel_i == SEL_CTRL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      period_q <= '0;
      en_q     <= 1'b0;
    end else if (wr_en_i) begin
      unique case (wr_sel_i)
        SEL_PER_LO: period_q[CNT_W-1:0]     <= wr_data_i;
        SEL_PER_HI: period_q[PER_W-1:CNT_W] <= wr_data_i[CNT_W-2:0];
        SEL_CTRL:   en_q                    <= wr_data_i[CTRL_EN];
        default:    ;
      endcase
    end
  end

  // arm only on an off->on transition
  assign arm_o    = ctrl_wr && wr_data_i[CTRL_EN] && !en_q;
  assign clr_o    = ctrl_wr && wr_data_i[CTRL_CLR];
  assign en_o     = en_q;
  assign period_o = period_q;
endmodule

// File: rtl/lpc_chunk_plan.sv
module lpc_chunk_plan #(
  parameter  int CNT_W = 32,
  localparam int REM_W = 2 * CNT_W
) (
  input  logic signed [REM_W-1:0] rem_i,
  output logic        [CNT_W-1:0] load_o,
  output logic        [CNT_W-1:0] len_o
);
  localparam logic [CNT_W-1:0] HALF_V = {1'b1, {(CNT_W-1){1'b0}}};

  logic big;

  // remaining >= half range: run a full pass
  assign big = !rem_i[REM_W-1] && (|rem_i[REM_W-2:CNT_W-1]);

  always_comb begin
    if (big) begin
      load_o = '0;
      len_o  = HALF_V;
    end else begin
      load_o = HALF_V - rem_i[CNT_W-1:0];
      len_o  = rem_i[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/lpc_irq_hold.sv
module lpc_irq_hold (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic irq_o
);
  logic irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    irq_q <= 1'b0;
    else if (set_i) irq_q <= 1'b1;
    else if (clr_i) irq_q <= 1'b0;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/lpc_sampler.sv
module lpc_sampler #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_sel_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             event_i,
  output logic             irq_o
);
  localparam int REM_W = 2 * CNT_W;
  localparam int PER_W = REM_W - 1;
  localparam int MSB   = CNT_W - 1;

  logic [PER_W-1:0]        period;
  logic                    en;
  logic                    arm;
  logic                    clr;
  logic signed [REM_W-1:0] period_eff;
  logic signed [REM_W-1:0] rem_q;
  logic signed [REM_W-1:0] rem_after;
  logic signed [REM_W-1:0] next_rem;
  logic [CNT_W-1:0]        cnt_q;
  logic [CNT_W-1:0]        len_q;
  logic [CNT_W-1:0]        plan_load;
  logic [CNT_W-1:0]        plan_len;
  logic                    ev;
  logic                    chunk_done;
  logic                    final_hit;

  lpc_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_sel_i (wr_sel_i),
    .wr_data_i(wr_data_i),
    .period_o (period),
    .en_o     (en),
    .arm_o    (arm),
    .clr_o    (clr)
  );

  assign period_eff = (period == '0) ? REM_W'(1) : REM_W'(period);
  assign ev         = event_i && en;
  assign chunk_done = en && cnt_q[MSB];
  assign rem_after  = rem_q - $signed(REM_W'(len_q));
  assign final_hit  = chunk_done && (rem_after[REM_W-1] || rem_after == '0);
  assign next_rem   = (arm || final_hit) ? period_eff : rem_after;

  lpc_chunk_plan #(.CNT_W(CNT_W)) u_plan (
    .rem_i (next_rem),
    .load_o(plan_load),
    .len_o (plan_len)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      rem_q <= '0;
      len_q <= '0;
    end else if (arm) begin
      cnt_q <= plan_load;
      rem_q <= next_rem;
      len_q <= plan_len;
    end else if (chunk_done) begin
      // reload pass; event in this cycle goes to the new pass
      cnt_q <= plan_load + CNT_W'(ev);
      rem_q <= next_rem;
      len_q <= plan_len;
    end else if (ev) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  lpc_irq_hold u_irq (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (final_hit),
    .clr_i (clr),
    .irq_o (irq_o)
  );
endmodule

// File: rtl/lpc_sampler_chk.sv
module lpc_sampler_chk #(
  parameter  int CNT_W = 32,
  localparam int REM_W = 2 * CNT_W
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    en_i,
  input logic                    cnt_msb_i,
  input logic                    event_i,
  input logic                    irq_i,
  input logic                    clr_i,
  input logic                    final_i,
  input logic signed [REM_W-1:0] rem_i,
  input logic [CNT_W-1:0]        len_i
);
  localparam logic [CNT_W-1:0] HALF_V = {1'b1, {(CNT_W-1){1'b0}}};

  AST_IRQ_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i && !clr_i |=> irq_i); // R9

  AST_IRQ_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !final_i |=> !irq_i); // R9

  AST_IRQ_ONLY_FINAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_i && !final_i |=> !irq_i); // R5

  AST_MSB_SELF_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && cnt_msb_i && !event_i |=> !cnt_msb_i); // R5

  AST_REM_POSITIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> (!rem_i[REM_W-1] && rem_i != '0)); // R4

  AST_CHUNK_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> (len_i != '0 && len_i <= HALF_V)); // R4
endmodule

bind lpc_sampler lpc_sampler_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .en_i     (en),
  .cnt_msb_i(cnt_q[CNT_W-1]),
  .event_i  (event_i),
  .irq_i    (irq_o),
  .clr_i    (clr),
  .final_i  (final_hit),
  .rem_i    (rem_q),
  .len_i    (len_q)
);

// File: tb/lpc_sampler_test.sv
`timescale 1ns/1ps
module lpc_sampler_test;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [1:0]   wr_sel = '0;
  logic [W-1:0] wr_data = '0;
  logic         event_in = 1'b0;
  logic         irq;

  int    checks = 0;
  int    fails = 0;
  string cur_req = "R1";
  bit    done = 1'b0;

  // reference model state
  int m_prog = 0;
  int m_cur = 1;
  int m_cnt = 0;
  bit m_en = 1'b0;
  bit m_pend = 1'b0;
  bit m_irq = 1'b0;

  lpc_sampler #(.CNT_W(W)) uut (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .wr_en_i  (wr_en),
    .wr_sel_i (wr_sel),
    .wr_data_i(wr_data),
    .event_i  (event_in),
    .irq_o    (irq)
  );

  always #5 clk = ~clk;

  function automatic int eff(int p);
    return (p == 0) ? 1 : p;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_prog = 0; m_cur = 1; m_cnt = 0; m_en = 0; m_pend = 0; m_irq = 0;
    end else begin
      if (m_pend) m_irq = 1;
      else if (wr_en && wr_sel == 2'd2 && wr_data[1]) m_irq = 0;
      m_pend = 0;
      if (m_en && event_in) begin
        m_cnt++;
        if (m_cnt >= m_cur) begin
          m_pend = 1;
          m_cnt = 0;
          m_cur = eff(m_prog);
        end
      end
      if (wr_en) begin
        case (wr_sel)
          2'd0: m_prog = (m_prog & ~32'hFF) | int'(wr_data);
          2'd1: m_prog = (m_prog & 32'hFF) | (int'(wr_data[W-2:0]) << 8);
          2'd2: begin
            if (wr_data[0] && !m_en) begin
              m_cnt = 0;
              m_cur = eff(m_prog);
            end
            m_en = wr_data[0];
          end
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (irq !== m_irq) begin
        fails++;
        $display("FAIL %s irq_o=%b expected=%b at %0t", cur_req, irq, m_irq, $time);
      end
    end
  end

  task automatic wr(input logic [1:0] sel, input logic [W-1:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_period(input int p);
    wr(2'd0, W'(p));
    wr(2'd1, W'(p >> 8));
  endtask

  task automatic ctrl(input bit en, input bit clr_b);
    wr(2'd2, W'({clr_b, en}));
  endtask

  task automatic send(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) event_in = 1'b1;
      if (gap > 0) begin
        @(negedge clk) event_in = 1'b0;
        repeat (gap - 1) @(negedge clk);
      end
    end
    @(negedge clk) event_in = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog %s irq_o=%b expected=run complete", cur_req, irq);
    finish_run();
  end

  initial begin
    int plist[3];
    string tags[3];
    plist = '{128, 129, 256};
    tags  = '{"R4", "R4", "R2"};

    // R1: reset state
    repeat (3) @(negedge clk);
    checks++;
    if (irq !== 1'b0) begin
      fails++;
      $display("FAIL R1 irq_o=%b expected=0 in reset", irq);
    end
    rst_n = 1'b1;
    idle(3);

    // R8: zero period acts as one
    cur_req = "R8";
    set_period(0);
    ctrl(1, 0);
    send(1, 3);
    idle(3);
    cur_req = "R9";
    ctrl(1, 1);
    idle(3);

    // R3: events ignored while disabled, arm restarts period
    cur_req = "R3";
    ctrl(0, 0);
    set_period(5);
    send(6, 1);
    idle(3);
    ctrl(1, 0);
    cur_req = "R6";
    send(4, 2);
    idle(4);
    send(1, 0);
    idle(4);
    cur_req = "R9";
    ctrl(1, 1);
    idle(2);

    // R4 R5: long period across several passes
    cur_req = "R5";
    ctrl(0, 0);
    set_period(300);
    ctrl(1, 0);
    send(299, 0);
    idle(5);
    cur_req = "R4";
    send(1, 0);
    idle(4);
    ctrl(1, 1);
    idle(2);

    // R4 R2: pass boundary periods
    for (int k = 0; k < 3; k++) begin
      cur_req = tags[k];
      ctrl(0, 0);
      set_period(plist[k]);
      ctrl(1, 0);
      send(plist[k] - 1, 0);
      idle(3);
      send(1, 1);
      idle(4);
      ctrl(1, 1);
      idle(2);
    end

    // R7: back-to-back periods with a continuous stream
    cur_req = "R7";
    ctrl(0, 0);
    set_period(3);
    ctrl(1, 0);
    send(12, 0);
    idle(4);
    ctrl(1, 1);
    idle(2);

    // R9: clears overlapping completions
    cur_req = "R9";
    fork
      send(30, 0);
      begin
        idle(6);
        ctrl(1, 1);
        idle(1);
        ctrl(1, 1);
        idle(3);
        ctrl(1, 1);
      end
    join
    idle(4);
    ctrl(1, 1);
    idle(2);

    // R10: period rewrite applies from next period
    cur_req = "R10";
    ctrl(0, 0);
    set_period(4);
    ctrl(1, 0);
    send(2, 1);
    set_period(6);
    send(2, 1);
    idle(4);
    ctrl(1, 1);
    send(5, 1);
    idle(4);
    send(1, 1);
    idle(4);

    finish_run();
  end
endmodule